// File: doc/BRIEF.md
# UART Interrupt Status and Control Unit

This block sits between the register bus of a high-speed UART and its data path. It holds the 32-bit control word that configures the transmit and receive FIFO triggers, the three interrupt enables and the forced line break. It also holds the interrupt status word. The status word combines three kinds of bit. Some are sticky error flags that receive-path event pulses set. Some are live copies of the receive request levels. One is a transmit request that latches when the transmit FIFO drains to its trigger level. Software reads the status word, clears the sticky bits by writing ones and can raise the transmit request itself.

Each status bit is gated by the enable of its group, and the gated bits are ORed onto one registered interrupt line. Register access uses plain write and read strobes with a small word address. The status word is at address 0, the control word at address 1, and the FIFO fill levels at address 2. A read returns its data on the cycle after the strobe. The FIFOs and the serial shifters are outside this block.

Top module: `uart_isc_top`

## Requirements
- R1: After a synchronous reset the control word, the status word, `irq_o` and `break_o` are all zero.
- R2: A write to address 1 stores all 32 bits, which read back unchanged. From the clock edge that takes the write, `tx_trig_code` follows control bits 1:0, `rx_trig_code` follows bits 4:2 and `break_o` follows bit 8.
- R3: Status bits 3 (framing), 4 (break) and 5 (overrun) are set by a one-cycle pulse on `evt_fe`, `evt_brk` and `evt_oe`. They stay set until a write to address 0 with a 1 in that bit position, and a 0 in a position leaves the bit unchanged.
- R4: When an event pulse and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Status bits 1 and 2 always show the current `rx_trig_req` and `rx_tmo_req` at the time of the read, and writes to those positions have no effect.
- R6: Status bit 0 latches in the cycle when `tx_level` goes from above to at or below the threshold picked by control bits 1:0 (0: 0, 1: 4, 2: 8, 3: 16 entries). It does not latch again while the level stays at or below the threshold, and writing a 1 to bit 0 clears it.
- R7: Writing a 1 to status bit 6 sets status bit 0. Bit 6 always reads 0.
- R8: The interrupt line is the OR of three terms. The first is status bit 0 gated by control bit 5. The second is status bits 1 or 2 gated by control bit 6. The third is any of status bits 3, 4 or 5 gated by control bit 7. The line reflects its sources one clock after they change.
- R9: A read of address 2 returns `tx_level` in bits 15:8 and `rx_level` in bits 7:0, with the upper bits zero.
- R10: `rdata` changes only on a read. It carries the addressed value one cycle after `rd_en`. Unmapped addresses read 0, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| evt_brk | input | 1 | Break-received pulse |
| evt_fe | input | 1 | Framing-error pulse |
| evt_oe | input | 1 | Receive overrun pulse |
| rx_trig_req | input | 1 | Receive FIFO at trigger level |
| rx_tmo_req | input | 1 | Receive inactivity timeout |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_trig_code | output | 2 | Transmit trigger selection |
| rx_trig_code | output | 3 | Receive trigger selection |
| break_o | output | 1 | Force transmit line to break |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the collision of an event pulse with a clear of the same bit. A design that let the clear win would drop an error that software never saw. It walks the transmit level down past each threshold and then holds it below. A level-sensitive latch would re-raise the request right after software cleared it, and an off-by-one comparison would fire one entry early or late. It toggles each enable while its sources stay fixed and writes to the live receive bits, so that crossed masks or writable live bits show up on the interrupt line or in the status read. Each cycle is compared with a behavioural model, which catches an interrupt line that lags by an extra register.

// File: rtl/uart_isc_pkg.sv
package uart_isc_pkg;

  // status word bit positions (software decodes these)
  localparam int ST_TX     = 0;
  localparam int ST_RXTRIG = 1;
  localparam int ST_RXTMO  = 2;
  localparam int ST_FE     = 3;
  localparam int ST_BRK    = 4;
  localparam int ST_OE     = 5;
  localparam int ST_TXSET  = 6;
  localparam int ST_W      = 7;

  // control word bit positions
  localparam int CT_TXCODE_LO = 0;
  localparam int CT_RXCODE_LO = 2;
  localparam int CT_TXEN      = 5;
  localparam int CT_RXEN      = 6;
  localparam int CT_ERREN     = 7;
  localparam int CT_BRK       = 8;

  // number of sticky error flags (framing, break, overrun)
  localparam int N_ERR = 3;

  // register word addresses
  localparam int ADR_STAT = 0;
  localparam int ADR_CTRL = 1;
  localparam int ADR_LVL  = 2;

  // transmit threshold in entries for a trigger code: 0, 4, 8, 16
  function automatic int tx_thresh(input logic [1:0] code);
    return (code == 2'd0) ? 0 : (2 << code);
  endfunction

endpackage

// File: rtl/uart_isc_ctrl_reg.sv
module uart_isc_ctrl_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] ctrl_d
);

  always_comb ctrl_d = wr_ctrl ? wdata : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/uart_isc_status.sv
module uart_isc_status
  import uart_isc_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       tx_code,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [N_ERR-1:0] evt,        // 0 framing, 1 break, 2 overrun
  input  logic             rx_trig,
  input  logic             rx_tmo,
  input  logic             w1c_wr,
  input  logic [ST_W-1:0]  w1c_data,
  output logic             tx_q,
  output logic             tx_d,
  output logic [N_ERR-1:0] err_q,
  output logic [N_ERR-1:0] err_d,
  output logic [ST_W-1:0]  status
);

  logic [LVL_W-1:0] thr;
  logic             below;
  logic             below_q;
  logic             tx_set;
  logic             tx_clr;
  logic [N_ERR-1:0] err_clr;

  // threshold compare against the selected trigger code
  always_comb begin
    thr   = LVL_W'(tx_thresh(tx_code));
    below = (tx_level <= thr);
  end

  // transmit request: set on the crossing or by software, W1C otherwise
  always_comb begin
    tx_set = (below & ~below_q) | (w1c_wr & w1c_data[ST_TXSET]);
    tx_clr = w1c_wr & w1c_data[ST_TX];
    tx_d   = tx_set | (tx_q & ~tx_clr);
  end

  // below_q resets to 1 so an idle empty FIFO raises nothing at reset
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= 1'b0;
      below_q <= 1'b1;
    end else begin
      tx_q    <= tx_d;
      below_q <= below;
    end
  end

  // sticky error flags, identical per source
  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    always_comb begin
      err_clr[i] = w1c_wr & w1c_data[ST_FE + i];
      err_d[i]   = evt[i] | (err_q[i] & ~err_clr[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) err_q[i] <= 1'b0;
      else     err_q[i] <= err_d[i];
    end

    // R3
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (err_q[i] && !err_clr[i]) |=> err_q[i]);

    // R4
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> err_q[i]);
  end

  // status word as software sees it; bit 6 reads zero
  always_comb begin
    status            = '0;
    status[ST_TX]     = tx_q;
    status[ST_RXTRIG] = rx_trig;
    status[ST_RXTMO]  = rx_tmo;
    status[ST_FE]     = err_q[0];
    status[ST_BRK]    = err_q[1];
    status[ST_OE]     = err_q[2];
  end

  // R6
  tx_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (below && !below_q) |=> tx_q);

  // R7
  tx_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (w1c_wr && w1c_data[ST_TXSET]) |=> tx_q);

endmodule

// File: rtl/uart_isc_irq.sv
module uart_isc_irq
  import uart_isc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_d,
  input  logic [N_ERR-1:0] err_d,
  input  logic             rx_trig,
  input  logic             rx_tmo,
  input  logic             en_tx,
  input  logic             en_rx,
  input  logic             en_err,
  output logic             irq_q
);

  logic irq_d;

  // built from next-state so the line moves on the edge that latches a flag
  always_comb
    irq_d = (tx_d & en_tx) | ((rx_trig | rx_tmo) & en_rx) | ((|err_d) & en_err);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end

endmodule

// File: rtl/uart_isc_top.sv
module uart_isc_top
  import uart_isc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              evt_brk,
  input  logic              evt_fe,
  input  logic              evt_oe,
  input  logic              rx_trig_req,
  input  logic              rx_tmo_req,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  output logic [1:0]        tx_trig_code,
  output logic [2:0]        rx_trig_code,
  output logic              break_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(ADR_LVL);

  logic              wr_stat, wr_ctrl;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              tx_q, tx_d;
  logic [N_ERR-1:0]  err_q, err_d;
  logic [ST_W-1:0]   status;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    wr_stat = wr_en && (addr == A_STAT);
    wr_ctrl = wr_en && (addr == A_CTRL);
  end

  uart_isc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_ctrl(wr_ctrl),
    .wdata  (wdata),
    .ctrl_q (ctrl_q),
    .ctrl_d (ctrl_d)
  );

  uart_isc_status #(.LVL_W(LVL_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .tx_code (ctrl_q[CT_TXCODE_LO +: 2]),
    .tx_level(tx_level),
    .evt     ({evt_oe, evt_brk, evt_fe}),
    .rx_trig (rx_trig_req),
    .rx_tmo  (rx_tmo_req),
    .w1c_wr  (wr_stat),
    .w1c_data(wdata[ST_W-1:0]),
    .tx_q    (tx_q),
    .tx_d    (tx_d),
    .err_q   (err_q),
    .err_d   (err_d),
    .status  (status)
  );

  uart_isc_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .tx_d   (tx_d),
    .err_d  (err_d),
    .rx_trig(rx_trig_req),
    .rx_tmo (rx_tmo_req),
    .en_tx  (ctrl_d[CT_TXEN]),
    .en_rx  (ctrl_d[CT_RXEN]),
    .en_err (ctrl_d[CT_ERREN]),
    .irq_q  (irq_o)
  );

  // read port: selected word captured on the strobe, held otherwise
  always_comb begin
    rd_mux = '0;
    if (addr == A_STAT)      rd_mux = DATA_W'(status);
    else if (addr == A_CTRL) rd_mux = ctrl_q;
    else if (addr == A_LVL)  rd_mux = DATA_W'({tx_level, rx_level});
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  always_comb begin
    rdata        = rdata_q;
    tx_trig_code = ctrl_q[CT_TXCODE_LO +: 2];
    rx_trig_code = ctrl_q[CT_RXCODE_LO +: 3];
    break_o      = ctrl_q[CT_BRK];
  end

  // R2
  break_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (break_o == $past(wdata[CT_BRK])));

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == ((tx_q & ctrl_q[CT_TXEN])
                      | (($past(rx_trig_req) | $past(rx_tmo_req)) & ctrl_q[CT_RXEN])
                      | ((|err_q) & ctrl_q[CT_ERREN]))));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/tb_uart_isc_top.sv
module tb_uart_isc_top;

  localparam int DW = 32;
  localparam int LW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          evt_brk = 1'b0, evt_fe = 1'b0, evt_oe = 1'b0;
  logic          rx_trig_req = 1'b0, rx_tmo_req = 1'b0;
  logic [LW-1:0] tx_level = 8'd64, rx_level = 8'd0;
  logic [1:0]    tx_trig_code;
  logic [2:0]    rx_trig_code;
  logic          break_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_isc_top #(.DATA_W(DW), .LVL_W(LW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_brk(evt_brk), .evt_fe(evt_fe),
    .evt_oe(evt_oe), .rx_trig_req(rx_trig_req), .rx_tmo_req(rx_tmo_req),
    .tx_level(tx_level), .rx_level(rx_level), .tx_trig_code(tx_trig_code),
    .rx_trig_code(rx_trig_code), .break_o(break_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  logic [DW-1:0] m_ctrl, m_rd;
  bit m_tx, m_fe, m_brk, m_oe, m_below, m_irq;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_rd = '0; m_tx = 0; m_fe = 0; m_brk = 0; m_oe = 0;
      m_below = 1; m_irq = 0;
    end else begin
      int thr;
      bit below, wst, n_tx, n_fe, n_brk, n_oe;
      if (rd_en) begin
        case (addr)
          2'd0: m_rd = {25'd0, m_oe, m_brk, m_fe, rx_tmo_req, rx_trig_req, m_tx};
          2'd1: m_rd = m_ctrl;
          2'd2: m_rd = {16'd0, tx_level, rx_level};
          default: m_rd = '0;
        endcase
      end
      case (m_ctrl[1:0])
        2'd0: thr = 0;
        2'd1: thr = 4;
        2'd2: thr = 8;
        default: thr = 16;
      endcase
      below = (int'(tx_level) <= thr);
      wst   = wr_en && (addr == 2'd0);
      n_tx  = (below && !m_below) || (wst && wdata[6]) || (m_tx && !(wst && wdata[0]));
      n_fe  = evt_fe  || (m_fe  && !(wst && wdata[3]));
      n_brk = evt_brk || (m_brk && !(wst && wdata[4]));
      n_oe  = evt_oe  || (m_oe  && !(wst && wdata[5]));
      m_below = below;
      if (wr_en && addr == 2'd1) m_ctrl = wdata;
      m_tx = n_tx; m_fe = n_fe; m_brk = n_brk; m_oe = n_oe;
      m_irq = (m_tx && m_ctrl[5]) || ((rx_trig_req || rx_tmo_req) && m_ctrl[6])
           || ((m_fe || m_brk || m_oe) && m_ctrl[7]);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(DW'(irq_o), DW'(m_irq), "R8 model irq");
      chk(DW'(break_o), DW'(m_ctrl[8]), "R2 model break");
      chk(DW'(tx_trig_code), DW'(m_ctrl[1:0]), "R2 model tx code");
      chk(DW'(rx_trig_code), DW'(m_ctrl[4:2]), "R2 model rx code");
      chk(rdata, m_rd, "R10 model rdata");
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(DW'(irq_o), 0, "R1 irq");
    chk(DW'(break_o), 0, "R1 break");
    rd_chk(2'd0, 32'h0, "R1 status");
    rd_chk(2'd1, 32'h0, "R1 control");

    // R2 control register
    wr(2'd1, 32'hABCD_01E6);
    chk(DW'(break_o), 1, "R2 break on");
    chk(DW'(tx_trig_code), 2, "R2 tx code");
    chk(DW'(rx_trig_code), 1, "R2 rx code");
    rd_chk(2'd1, 32'hABCD_01E6, "R2 readback");
    wr(2'd1, 32'h0000_00E6);
    chk(DW'(break_o), 0, "R2 break off");

    // R6 transmit threshold 8
    tx_level = 8'd9; idle(2);
    rd_chk(2'd0, 32'h00, "R6 above threshold");
    tx_level = 8'd8; idle(1);
    rd_chk(2'd0, 32'h01, "R6 at threshold");
    chk(DW'(irq_o), 1, "R8 tx irq");
    tx_level = 8'd5;
    wr(2'd0, 32'h01);
    idle(2);
    rd_chk(2'd0, 32'h00, "R6 no relatch");
    chk(DW'(irq_o), 0, "R8 tx irq cleared");
    tx_level = 8'd20; idle(1);
    tx_level = 8'd8; idle(1);
    rd_chk(2'd0, 32'h01, "R6 second crossing");
    wr(2'd0, 32'h01);
    tx_level = 8'd64;
    // R6 empty threshold
    wr(2'd1, 32'h0000_00E4);
    tx_level = 8'd1; idle(1);
    rd_chk(2'd0, 32'h00, "R6 code0 level1");
    tx_level = 8'd0; idle(1);
    rd_chk(2'd0, 32'h01, "R6 code0 empty");
    wr(2'd0, 32'h01);
    tx_level = 8'd64;
    // R6 threshold 16
    wr(2'd1, 32'h0000_00E7);
    tx_level = 8'd17; idle(1);
    rd_chk(2'd0, 32'h00, "R6 code3 level17");
    tx_level = 8'd16; idle(1);
    rd_chk(2'd0, 32'h01, "R6 code3 level16");
    wr(2'd0, 32'h01);
    tx_level = 8'd64;
    wr(2'd1, 32'h0000_00E6);

    // R7 software set
    wr(2'd0, 32'h40);
    rd_chk(2'd0, 32'h01, "R7 set by bit6");
    wr(2'd0, 32'h01);
    rd_chk(2'd0, 32'h00, "R7 cleared");

    // R3 sticky errors
    @(negedge clk); evt_fe = 1'b1; @(negedge clk); evt_fe = 1'b0;
    rd_chk(2'd0, 32'h08, "R3 framing");
    @(negedge clk); evt_brk = 1'b1; @(negedge clk); evt_brk = 1'b0;
    rd_chk(2'd0, 32'h18, "R3 break");
    @(negedge clk); evt_oe = 1'b1; @(negedge clk); evt_oe = 1'b0;
    rd_chk(2'd0, 32'h38, "R3 overrun");
    chk(DW'(irq_o), 1, "R8 err irq");
    wr(2'd0, 32'h00);
    rd_chk(2'd0, 32'h38, "R3 zero write");
    wr(2'd0, 32'h10);
    rd_chk(2'd0, 32'h28, "R3 clear break");
    wr(2'd0, 32'h28);
    rd_chk(2'd0, 32'h00, "R3 clear rest");
    chk(DW'(irq_o), 0, "R8 err irq cleared");

    // R4 set wins over clear
    @(negedge clk); evt_fe = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 32'h08;
    @(negedge clk); evt_fe = 1'b0; wr_en = 1'b0;
    rd_chk(2'd0, 32'h08, "R4 set wins");
    wr(2'd0, 32'h08);

    // R5 live receive bits
    rx_trig_req = 1'b1; idle(1);
    rd_chk(2'd0, 32'h02, "R5 trigger live");
    wr(2'd0, 32'h06);
    rd_chk(2'd0, 32'h02, "R5 write ignored");
    rx_tmo_req = 1'b1; idle(1);
    rd_chk(2'd0, 32'h06, "R5 timeout live");
    rx_trig_req = 1'b0; rx_tmo_req = 1'b0; idle(1);
    rd_chk(2'd0, 32'h00, "R5 both dropped");

    // R8 masking per group
    wr(2'd1, 32'h0000_0002);
    rx_trig_req = 1'b1; idle(2);
    chk(DW'(irq_o), 0, "R8 rx masked");
    @(negedge clk); evt_oe = 1'b1; @(negedge clk); evt_oe = 1'b0;
    chk(DW'(irq_o), 0, "R8 err masked");
    wr(2'd1, 32'h0000_0082);
    chk(DW'(irq_o), 1, "R8 err enabled");
    wr(2'd1, 32'h0000_0042);
    chk(DW'(irq_o), 1, "R8 rx enabled");
    rx_trig_req = 1'b0; idle(1);
    chk(DW'(irq_o), 0, "R8 rx dropped err masked");
    wr(2'd0, 32'h20);
    rd_chk(2'd0, 32'h00, "R8 clean");

    // R9 level register
    tx_level = 8'd37; rx_level = 8'd13; idle(1);
    rd_chk(2'd2, 32'h0000_250D, "R9 levels");
    tx_level = 8'd64; rx_level = 8'd0;

    // R10 unmapped address and side-effect-free reads
    rd_chk(2'd3, 32'h0, "R10 unmapped");
    @(negedge clk); evt_brk = 1'b1; @(negedge clk); evt_brk = 1'b0;
    rd_chk(2'd0, 32'h10, "R10 first read");
    rd_chk(2'd0, 32'h10, "R10 second read");
    idle(3);
    chk(rdata, 32'h10, "R10 held");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule